// File: doc/BRIEF.md
# Dual-Mode FIFO Controller

This block is a single-clock FIFO controller with a write port, a read port and a small storage array whose depth is set by a parameter. It has two read modes, and the mode is captured while the master reset is held. In standard mode a word stays in storage until a read request moves it into the output register. The read-side flag then means "empty" and the write-side flag means "full". In fall-through mode the oldest stored word moves into the output register by itself. The read-side flag then means "output valid" and the write-side flag means "space available", and the output register counts as one more storage slot.

Two threshold inputs come from a separate offset block and drive an almost-empty flag and an almost-full flag. The active-low master reset clears the block and latches the mode. The synchronous partial reset throws away all stored data and keeps the latched mode. A producer may write only while the write side can accept: the write-side flag is low in standard mode or high in fall-through mode. A write at any other time is dropped, and this is the only back-pressure the block applies. A consumer pulls words with `rd_en`. A pull is honoured only when a word is available and is otherwise ignored.

Top module: `dfifo_ctl`

## Requirements
- R1: The mode is latched from `cfg_fwft` while `rst_n` is low (0 = standard, 1 = fall-through). After master reset, `almost_empty`=1 and `almost_full`=0. `rd_flag`=1 in standard mode and 0 in fall-through mode. `wr_flag`=0 in standard mode and 1 in fall-through mode.
- R2: A one-cycle `part_rst` empties the FIFO, with the same flag values as R1, and the mode latched at the last master reset is kept.
- R3: In standard mode a word written into an empty FIFO does not reach `rd_data`. A read accepted at a clock edge puts the oldest word on `rd_data` right after that edge.
- R4: In fall-through mode the first word written into an empty FIFO appears on `rd_data`, with `rd_flag`=1, two edges after its write and with no read. It stays there until a read.
- R5: Words leave in the order in which they were written, in both modes.
- R6: In standard mode `wr_flag` rises once DEPTH words are stored. A write while `wr_flag`=1 is dropped.
- R7: In fall-through mode `wr_flag` falls only when DEPTH+1 words are held (storage full and output register occupied). A write while it is 0 is dropped.
- R8: A read while no word is available leaves `rd_data` unchanged. No word is available when `rd_flag`=1 in standard mode or `rd_flag`=0 in fall-through mode.
- R9: `almost_empty` is 1 exactly when the held word count is at or below `ae_off`.
- R10: `almost_full` is 1 exactly when the free space (DEPTH, or DEPTH+1 in fall-through mode, minus the held count) is at or below `af_off`.
- R11: A write and a read accepted in the same cycle leave the held count unchanged and keep the order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst_n | input | 1 | Master reset, asynchronous, active low; latches the mode |
| part_rst | input | 1 | Synchronous flush that keeps the mode |
| cfg_fwft | input | 1 | Mode select, sampled while rst_n is low |
| ae_off | input | AW+1 | Almost-empty threshold |
| af_off | input | AW+1 | Almost-full threshold |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write data |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Output register |
| rd_flag | output | 1 | Empty (standard) or output valid (fall-through) |
| wr_flag | output | 1 | Full (standard) or space available (fall-through) |
| almost_empty | output | 1 | Held count at or below ae_off |
| almost_full | output | 1 | Free space at or below af_off |

## Verification
The assertions assume that both thresholds are below DEPTH and are held steady. Without that, the flag values after a flush and at the storage limits would not be defined. They also assume that `part_rst` is pulsed only while `rst_n` is high. The bench keeps both thresholds at 2 for the whole run and changes `cfg_fwft` only while the master reset is held. It drives every other input away from the rising edge, so each request is seen at exactly one edge.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;
  typedef enum logic {
    MODE_STD  = 1'b0,
    MODE_FWFT = 1'b1
  } rdmode_e;
endpackage

// File: rtl/fctl_ptrs.sv
// Write/read pointers and the count of words held in the storage array.
module fctl_ptrs #(
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic          pop,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] rptr,
  output logic [AW:0]   cnt
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else if (flush) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (push) wptr <= wptr + 1'b1;
      if (pop)  rptr <= rptr + 1'b1;
      case ({push, pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/fctl_store.sv
// Storage array: one write port, asynchronous read.
module fctl_store #(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  assign rdata = cells[raddr];
endmodule

// File: rtl/fctl_outstage.sv
// Output register and its mode-dependent loading rule.
module fctl_outstage
  import dfifo_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  rdmode_e       mode,
  input  logic          mem_nz,
  input  logic          rd_en,
  input  logic [DW-1:0] mem_rdata,
  output logic          pop_mem,
  output logic          ovld,
  output logic [DW-1:0] dout
);
  logic take;

  always_comb begin
    if (mode == MODE_FWFT) begin
      take    = ovld & rd_en;
      pop_mem = mem_nz & (~ovld | take);
    end else begin
      take    = 1'b0;
      pop_mem = rd_en & mem_nz;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovld <= 1'b0;
      dout <= '0;
    end else if (flush) begin
      ovld <= 1'b0;
      dout <= '0;
    end else begin
      if (pop_mem) dout <= mem_rdata;
      if (mode == MODE_FWFT) ovld <= pop_mem | (ovld & ~take);
      else                   ovld <= 1'b0;
    end
  end
endmodule

// File: rtl/fctl_flags.sv
// Flag generation from the registered occupancy state.
module fctl_flags
  import dfifo_pkg::*;
#(
  parameter int AW = 3
) (
  input  rdmode_e     mode,
  input  logic [AW:0] cnt,
  input  logic        ovld,
  input  logic [AW:0] ae_off,
  input  logic [AW:0] af_off,
  output logic        rd_flag,
  output logic        wr_flag,
  output logic        wr_ok,
  output logic        almost_empty,
  output logic        almost_full
);
  localparam int DEPTH = 1 << AW;
  localparam int CW    = AW + 1;
  localparam logic [AW:0] DEPTH_C = CW'(DEPTH);
  localparam logic [AW:0] CAP_FW  = CW'(DEPTH + 1);

  logic [AW:0] occ;
  logic [AW:0] cap;
  logic [AW:0] free_n;
  logic        mem_full;

  always_comb begin
    mem_full = (cnt == DEPTH_C);
    occ      = cnt + CW'(ovld);
    cap      = (mode == MODE_FWFT) ? CAP_FW : DEPTH_C;
    free_n   = cap - occ;
    if (mode == MODE_FWFT) begin
      rd_flag = ovld;
      wr_flag = ~(mem_full & ovld);
      wr_ok   = wr_flag;
    end else begin
      rd_flag = (cnt == '0);
      wr_flag = mem_full;
      wr_ok   = ~mem_full;
    end
    almost_empty = (occ <= ae_off);
    almost_full  = (free_n <= af_off);
  end
endmodule

// File: rtl/dfifo_ctl.sv
module dfifo_ctl
  import dfifo_pkg::*;
#(
  parameter int DW = 8,
  parameter int AW = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          part_rst,
  input  logic          cfg_fwft,
  input  logic [AW:0]   ae_off,
  input  logic [AW:0]   af_off,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_flag,
  output logic          wr_flag,
  output logic          almost_empty,
  output logic          almost_full
);
  rdmode_e       mode_q;
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;
  logic          wr_ok, push, pop_mem, ovld;
  logic [DW-1:0] mem_rdata;

  // Mode follows cfg_fwft for as long as the master reset is held.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= rdmode_e'(cfg_fwft);
    else        mode_q <= mode_q;
  end

  assign push = wr_en & wr_ok & ~part_rst;

  fctl_ptrs #(.AW(AW)) u_ptrs (
    .clk(clk), .rst_n(rst_n), .flush(part_rst),
    .push(push), .pop(pop_mem),
    .wptr(wptr), .rptr(rptr), .cnt(cnt)
  );

  fctl_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .we(push), .waddr(wptr), .wdata(wr_data),
    .raddr(rptr), .rdata(mem_rdata)
  );

  fctl_outstage #(.DW(DW)) u_out (
    .clk(clk), .rst_n(rst_n), .flush(part_rst), .mode(mode_q),
    .mem_nz(cnt != '0), .rd_en(rd_en), .mem_rdata(mem_rdata),
    .pop_mem(pop_mem), .ovld(ovld), .dout(rd_data)
  );

  fctl_flags #(.AW(AW)) u_flags (
    .mode(mode_q), .cnt(cnt), .ovld(ovld),
    .ae_off(ae_off), .af_off(af_off),
    .rd_flag(rd_flag), .wr_flag(wr_flag), .wr_ok(wr_ok),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );
endmodule

// File: rtl/dfifo_ctl_chk.sv
module dfifo_ctl_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          part_rst,
  input logic          fwft,
  input logic          wr_en,
  input logic          rd_en,
  input logic [DW-1:0] rd_data,
  input logic          rd_flag,
  input logic          wr_flag,
  input logic          almost_empty,
  input logic          almost_full
);
  assert_empty_read_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && rd_flag && rd_en && !part_rst) |=> $stable(rd_data));

  assert_full_stays_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && wr_flag && !rd_en && !part_rst) |=> wr_flag);

  assert_head_held_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && rd_flag && !rd_en && !part_rst) |=> (rd_flag && $stable(rd_data)));

  assert_flush_empties_R2: assert property (@(posedge clk) disable iff (!rst_n)
    part_rst |=> (almost_empty && !almost_full && (fwft ? !rd_flag : rd_flag)));

  assert_flush_keeps_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
    part_rst |=> $stable(fwft));

  assert_empty_is_almost_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && rd_flag) |-> almost_empty);

  assert_full_is_almost_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!fwft && wr_flag) |-> almost_full);

  assert_no_room_has_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && !wr_flag) |-> rd_flag);

  // A dropped write while space is closed must not open an extra slot.
  assert_blocked_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (fwft && !wr_flag && wr_en && !rd_en && !part_rst) |=> !wr_flag);
endmodule

bind dfifo_ctl dfifo_ctl_chk #(.DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .part_rst(part_rst), .fwft(mode_q),
  .wr_en(wr_en), .rd_en(rd_en), .rd_data(rd_data),
  .rd_flag(rd_flag), .wr_flag(wr_flag),
  .almost_empty(almost_empty), .almost_full(almost_full)
);

// File: tb/dfifo_ctl_test.sv
module dfifo_ctl_test;
  localparam int DW = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n, part_rst, cfg_fwft, wr_en, rd_en;
  logic [AW:0]   ae_off, af_off;
  logic [DW-1:0] wr_data, rd_data;
  logic          rd_flag, wr_flag, almost_empty, almost_full;
  int            nchk = 0;
  int            nerr = 0;

  always #2 clk = ~clk;

  dfifo_ctl #(.DW(DW), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .part_rst(part_rst), .cfg_fwft(cfg_fwft),
    .ae_off(ae_off), .af_off(af_off), .wr_en(wr_en), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_flag(rd_flag), .wr_flag(wr_flag),
    .almost_empty(almost_empty), .almost_full(almost_full)
  );

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step(input logic we, input logic [DW-1:0] wd, input logic re);
    @(negedge clk);
    wr_en = we; wr_data = wd; rd_en = re;
    @(posedge clk); #1;
    wr_en = 1'b0; rd_en = 1'b0;
  endtask

  task automatic pulse_flush();
    @(negedge clk); part_rst = 1'b1;
    @(posedge clk); #1; part_rst = 1'b0;
  endtask

  task automatic master_reset(input logic fw);
    @(negedge clk);
    rst_n = 1'b0; cfg_fwft = fw;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic t_reset_std();
    master_reset(1'b0);
    check("R1 std empty", rd_flag, 1);
    check("R1 std full", wr_flag, 0);
    check("R1 almost_empty", almost_empty, 1);
    check("R1 almost_full", almost_full, 0);
  endtask

  task automatic t_std_first_word();
    step(1'b1, 8'h11, 1'b0);
    check("R3 not empty", rd_flag, 0);
    check("R3 word stays in storage", rd_data, 0);
    step(1'b0, 8'h00, 1'b1);
    check("R3 read brings word", rd_data, 8'h11);
    check("R3 empty again", rd_flag, 1);
    step(1'b0, 8'h00, 1'b1);
    check("R8 read while empty holds data", rd_data, 8'h11);
    check("R8 still empty", rd_flag, 1);
  endtask

  task automatic t_std_fill();
    for (int i = 0; i < 8; i++) begin
      step(1'b1, 8'(8'h20 + i), 1'b0);
      check("R9 almost_empty std", almost_empty, (i + 1 <= 2) ? 1 : 0);
      check("R10 almost_full std", almost_full, (8 - (i + 1) <= 2) ? 1 : 0);
    end
    check("R6 full at depth", wr_flag, 1);
    step(1'b1, 8'hEE, 1'b0);
    check("R6 still full", wr_flag, 1);
    for (int i = 0; i < 8; i++) begin
      step(1'b0, 8'h00, 1'b1);
      check("R5 std order", rd_data, 8'h20 + i);
    end
    check("R6 dropped write not stored", rd_flag, 1);
    step(1'b0, 8'h00, 1'b1);
    check("R8 empty read after drain", rd_data, 8'h27);
  endtask

  task automatic t_std_simul();
    step(1'b1, 8'h30, 1'b0);
    step(1'b1, 8'h31, 1'b0);
    step(1'b1, 8'h32, 1'b0);
    step(1'b1, 8'h33, 1'b1);
    check("R11 read during write", rd_data, 8'h30);
    for (int i = 1; i < 4; i++) begin
      step(1'b0, 8'h00, 1'b1);
      check("R11 order kept", rd_data, 8'h30 + i);
    end
    check("R11 count kept", rd_flag, 1);
  endtask

  task automatic t_std_flush();
    step(1'b1, 8'h40, 1'b0);
    step(1'b1, 8'h41, 1'b0);
    pulse_flush();
    check("R2 std empty after flush", rd_flag, 1);
    check("R2 almost_empty after flush", almost_empty, 1);
    check("R2 not full after flush", wr_flag, 0);
    step(1'b1, 8'h42, 1'b0);
    step(1'b0, 8'h00, 1'b1);
    check("R2 old data gone", rd_data, 8'h42);
  endtask

  task automatic t_reset_fwft();
    master_reset(1'b1);
    check("R1 fwft no output", rd_flag, 0);
    check("R1 fwft input ready", wr_flag, 1);
    check("R1 fwft almost_empty", almost_empty, 1);
    check("R1 fwft almost_full", almost_full, 0);
  endtask

  task automatic t_fwft_first_word();
    step(1'b1, 8'h50, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    check("R4 output valid", rd_flag, 1);
    check("R4 word falls through", rd_data, 8'h50);
    step(1'b1, 8'h51, 1'b0);
    step(1'b1, 8'h52, 1'b0);
    check("R4 head held without read", rd_data, 8'h50);
    step(1'b0, 8'h00, 1'b1);
    check("R5 fwft next word", rd_data, 8'h51);
    step(1'b0, 8'h00, 1'b1);
    check("R5 fwft last word", rd_data, 8'h52);
    step(1'b0, 8'h00, 1'b1);
    check("R4 output invalid when drained", rd_flag, 0);
    step(1'b0, 8'h00, 1'b1);
    check("R8 fwft read while not ready", rd_data, 8'h52);
  endtask

  task automatic t_fwft_fill();
    for (int i = 0; i < 9; i++) begin
      step(1'b1, 8'(8'h60 + i), 1'b0);
      check("R7 input ready", wr_flag, (i < 8) ? 1 : 0);
      check("R9 almost_empty fwft", almost_empty, (i + 1 <= 2) ? 1 : 0);
      check("R10 almost_full fwft", almost_full, (9 - (i + 1) <= 2) ? 1 : 0);
    end
    step(1'b1, 8'hEE, 1'b0);
    check("R7 still not ready", wr_flag, 0);
    for (int i = 0; i < 9; i++) begin
      check("R5 fwft drain order", rd_data, 8'h60 + i);
      step(1'b0, 8'h00, 1'b1);
    end
    check("R7 dropped write not stored", rd_flag, 0);
  endtask

  task automatic t_fwft_flush();
    step(1'b1, 8'h70, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    pulse_flush();
    check("R2 fwft output cleared", rd_flag, 0);
    check("R2 fwft input ready", wr_flag, 1);
    step(1'b1, 8'h71, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    check("R2 mode kept falls through", rd_flag, 1);
    check("R2 mode kept data", rd_data, 8'h71);
  endtask

  initial begin
    rst_n = 1'b0; part_rst = 1'b0; cfg_fwft = 1'b0;
    wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
    ae_off = 4'd2; af_off = 4'd2;
    t_reset_std();
    t_std_first_word();
    t_std_fill();
    t_std_simul();
    t_std_flush();
    t_reset_fwft();
    t_fwft_first_word();
    t_fwft_fill();
    t_fwft_flush();
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end

  initial begin
    #100000;
    nchk++; nerr++;
    $display("FAIL watchdog R1 actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", nchk, nerr);
    $finish;
  end
endmodule